// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. An accepted sample is shifted into a tap delay line. The filter then walks the stored sample words from least to most significant bit. At each bit position it gathers that bit from every tap into an address. The address selects an entry in a table of precomputed coefficient sums, which is built at elaboration. Each table result is weighted by its bit position and folded into a right-shifting accumulator. After the last bit position has been handled, the accumulator holds the full-precision filter output.

The parameter `BPC` sets how many bit positions are handled per clock, either one or two. With two, a second lane reads the same table with the odd bit of each pair. That lane's result is doubled before accumulation. This halves the cycles spent on each sample. The cost is a second table read port and a wider adder.

Samples enter through a valid/ready handshake. The result appears with a one-cycle valid strobe.

Top module: `fir_da_serial`

## Requirements
- R1: While and right after the synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Each output equals the sum over taps t of c[t]·x[n−t]. Tap 0 holds the newest accepted sample. The value is given at full precision on DW+CW+ceil(log2(TAPS)) bits. Coefficient t sits in bits [t·CW +: CW] of `COEFS`.
- R3: Samples and coefficients are two's complement. A sample's MSB carries weight −2^(DW−1), so negative samples, including the most negative one, give exact results.
- R4: While `in_valid` is held, one sample is accepted every DW/BPC cycles.
- R5: In the cycle after an acceptance, `in_ready` is 0. It returns to 1 only in the cycle that handles the final bit group.
- R6: `out_valid` is a single-cycle pulse, issued exactly once per accepted sample.
- R7: `out_valid` is high in the cycle after the (DW/BPC)-th rising edge that follows the accepting edge. The latency is therefore one sample period in either mode.
- R8: Values on `in_valid` and `in_data` while `in_ready` is 0 are ignored. They affect neither the current output nor any later output.
- R9: With BPC=2, the odd-bit lane is weighted by two. The outputs are identical to the BPC=1 outputs for the same sample sequence, in half the cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW | Two's complement sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | DW+CW+ceil(log2(TAPS)) | Full-precision filter output |

## Verification
Several properties are checked by assertions on every cycle:
- the tap line shifts only on acceptance,
- the accumulator never leaves its guarded range,
- ready drops after every acceptance,
- the output strobe lasts a single cycle,
- the strobe lands exactly one sample period after its acceptance.

Other behaviours can only be shown by the bench's scenarios against a direct convolution model:
- the numerical result, including the negative weight of the sign bit;
- that data offered while ready is low is ignored;
- that the two-lane build matches the single-lane build at twice the rate.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    localparam int MAXCB    = 512;
    localparam int DEF_DW   = 8;
    localparam int DEF_CW   = 8;
    localparam int DEF_TAPS = 4;
    // tap3..tap0 = -128, 127, -91, 37
    localparam logic [DEF_TAPS*DEF_CW-1:0] DEF_COEFS = {8'h80, 8'h7F, 8'hA5, 8'h25};

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

    typedef struct packed {
        logic accept;
        logic last_grp;
    } step_ctl_t;

    function automatic int coef_at(input logic [MAXCB-1:0] flat, input int cw, input int t);
        int v;
        v = 0;
        for (int b = 0; b < cw; b++)
            if (flat[t*cw+b]) v += (b == cw-1) ? -(1 << b) : (1 << b);
        return v;
    endfunction

    function automatic int table_entry(input logic [MAXCB-1:0] flat, input int cw,
                                       input int taps, input int k);
        int s;
        s = 0;
        for (int t = 0; t < taps; t++)
            if (((k >> t) & 1) == 1) s += coef_at(flat, cw, t);
        return s;
    endfunction

endpackage

// File: rtl/da_psum_rom.sv
module da_psum_rom
    import fir_da_pkg::*;
#(
    parameter int TAPS = 4,
    parameter int CW   = 8,
    parameter int PW   = 10,
    parameter logic [TAPS*CW-1:0] COEFS = '0
) (
    input  logic [TAPS-1:0]        addr,
    output logic signed [PW-1:0]   psum
);
    localparam int ENTRIES = 1 << TAPS;

    logic signed [PW-1:0] tbl [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        assign tbl[k] = PW'(table_entry(MAXCB'(COEFS), CW, TAPS, k));
    end

    assign psum = tbl[addr];
endmodule

// File: rtl/da_tap_line.sv
module da_tap_line #(
    parameter int DW   = 8,
    parameter int TAPS = 4,
    parameter int BPC  = 1,
    parameter int SW   = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift,
    input  logic [DW-1:0]              din,
    input  logic [SW-1:0]              grp,
    output logic [BPC-1:0][TAPS-1:0]   slice
);
    localparam int IXW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] taps [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < TAPS; t++) taps[t] <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int t = 1; t < TAPS; t++) taps[t] <= taps[t-1];
        end
    end

    for (genvar l = 0; l < BPC; l++) begin : g_lane
        logic [IXW-1:0] bix;
        assign bix = IXW'(int'(grp) * BPC + l);
        always_comb begin
            for (int t = 0; t < TAPS; t++) slice[l][t] = taps[t][bix];
        end
    end

    // R2
    tap_load_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> (taps[0] == $past(din)));

    if (TAPS > 1) begin : g_shift_chk
        // R2
        tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
            shift |=> (taps[1] == $past(taps[0])));
    end
endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
    parameter int DW  = 8,
    parameter int PW  = 10,
    parameter int BPC = 1,
    parameter int IW  = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      clr,
    input  logic [BPC-1:0]            neg,
    input  logic [BPC-1:0][PW-1:0]    psums,
    output logic signed [IW-1:0]      acc_next
);
    logic signed [IW-1:0] acc;
    logic signed [IW-1:0] grp_sum;

    always_comb begin
        logic signed [IW-1:0] lane_v;
        grp_sum = '0;
        for (int l = 0; l < BPC; l++) begin
            lane_v = IW'($signed(psums[l]));
            if (neg[l]) lane_v = -lane_v;
            grp_sum = grp_sum + (lane_v <<< l);
        end
        acc_next = (acc >>> BPC) + (grp_sum <<< (DW - BPC));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= acc_next;
    end

    // R2
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (acc_next[IW-1] == acc_next[IW-2]));
endmodule

// File: rtl/fir_da_serial.sv
module fir_da_serial
    import fir_da_pkg::*;
#(
    parameter int DW   = DEF_DW,
    parameter int CW   = DEF_CW,
    parameter int TAPS = DEF_TAPS,
    parameter int BPC  = 1,
    parameter logic [TAPS*CW-1:0] COEFS = DEF_COEFS
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [DW-1:0]                          in_data,
    output logic                                   out_valid,
    output logic signed [DW+CW+$clog2(TAPS)-1:0]   out_data
);
    localparam int LG    = $clog2(TAPS);
    localparam int AW    = DW + CW + LG;
    localparam int IW    = AW + 2;
    localparam int PW    = CW + LG;
    localparam int STEPS = DW / BPC;
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    run_state_e                   st;
    logic [SW-1:0]                grp;
    step_ctl_t                    ctl;
    logic [BPC-1:0][TAPS-1:0]     slice;
    logic [BPC-1:0][PW-1:0]       psums;
    logic [BPC-1:0]               neg;
    logic signed [IW-1:0]         acc_next;

    always_comb begin
        ctl.last_grp = (st == ST_RUN) && (grp == SW'(STEPS - 1));
        in_ready     = (st == ST_IDLE) || ctl.last_grp;
        ctl.accept   = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            grp       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.last_grp;
            if (ctl.last_grp) out_data <= acc_next[AW-1:0];
            if (ctl.accept) begin
                st  <= ST_RUN;
                grp <= '0;
            end else if (ctl.last_grp) begin
                st <= ST_IDLE;
            end else if (st == ST_RUN) begin
                grp <= grp + 1'b1;
            end
        end
    end

    da_tap_line #(.DW(DW), .TAPS(TAPS), .BPC(BPC), .SW(SW)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .shift (ctl.accept),
        .din   (in_data),
        .grp   (grp),
        .slice (slice)
    );

    for (genvar l = 0; l < BPC; l++) begin : g_lane
        da_psum_rom #(.TAPS(TAPS), .CW(CW), .PW(PW), .COEFS(COEFS)) u_rom (
            .addr (slice[l]),
            .psum (psums[l])
        );
        assign neg[l] = ((int'(grp) * BPC + l) == DW - 1);
    end

    da_shift_acc #(.DW(DW), .PW(PW), .BPC(BPC), .IW(IW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (st == ST_RUN),
        .clr      (ctl.last_grp),
        .neg      (neg),
        .psums    (psums),
        .acc_next (acc_next)
    );

    int since_acc;
    always_ff @(posedge clk) begin
        if (rst)                                         since_acc <= 0;
        else if (ctl.accept)                             since_acc <= 1;
        else if (since_acc != 0 && since_acc < 2*STEPS)  since_acc <= since_acc + 1;
    end

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(since_acc) == STEPS));

    // R6
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    if (STEPS > 1) begin : g_ready_chk
        // R5
        ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
            ctl.accept |=> !in_ready);
    end
endmodule

// File: tb/sim_fir_da_serial.sv
`timescale 1ns/1ps
module sim_fir_da_serial;
    localparam int AW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 iv [2];
    logic [7:0]           id [2];
    logic                 ir [2];
    logic                 ov [2];
    logic signed [AW-1:0] od [2];

    fir_da_serial #(.BPC(1)) u0 (
        .clk(clk), .rst(rst), .in_valid(iv[0]), .in_ready(ir[0]),
        .in_data(id[0]), .out_valid(ov[0]), .out_data(od[0]));

    fir_da_serial #(.BPC(2)) u1 (
        .clk(clk), .rst(rst), .in_valid(iv[1]), .in_ready(ir[1]),
        .in_data(id[1]), .out_valid(ov[1]), .out_data(od[1]));

    int cf [4] = '{37, -91, 127, -128};
    int n_chk = 0, n_bad = 0, cyc = 0;
    int h [2][4];
    int last_acc [2];
    bit prev_ov [2];
    bit done = 0;
    int q_val0[$], q_cyc0[$], q_val1[$], q_cyc1[$];
    string q_tag0[$], q_tag1[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int steps_of(input int d);
        return (d == 0) ? 8 : 4;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(input int d, input int x, input bit junk, input bit stream);
        int y, a;
        string tag;
        while (!ir[d]) begin
            iv[d] = junk;
            id[d] = 8'h5A ^ x[7:0];
            @(negedge clk);
        end
        iv[d] = 1'b1;
        id[d] = x[7:0];
        a = cyc + 1;
        // R4 back-to-back acceptance spacing
        if (stream && last_acc[d] >= 0)
            check(a - last_acc[d] == steps_of(d), "R4", "accept spacing",
                  a - last_acc[d], steps_of(d));
        last_acc[d] = a;
        for (int t = 3; t > 0; t--) h[d][t] = h[d][t-1];
        h[d][0] = x;
        y = 0;
        for (int t = 0; t < 4; t++) y += cf[t] * h[d][t];
        if (junk)        tag = "R8";
        else if (d == 1) tag = "R9";
        else if (x < 0)  tag = "R3";
        else             tag = "R2";
        if (d == 0) begin q_val0.push_back(y); q_cyc0.push_back(a); q_tag0.push_back(tag); end
        else        begin q_val1.push_back(y); q_cyc1.push_back(a); q_tag1.push_back(tag); end
        @(negedge clk);
        iv[d] = 1'b0;
        // R5 ready low right after acceptance
        check(ir[d] == 1'b0, "R5", "ready after accept", ir[d], 0);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int d = 0; d < 2; d++) begin
                if (ov[d]) begin
                    int ev, ec;
                    string tg;
                    // R6 single-cycle strobe
                    check(!prev_ov[d], "R6", "strobe width", prev_ov[d], 0);
                    if ((d == 0 && q_val0.size() == 0) || (d == 1 && q_val1.size() == 0)) begin
                        check(0, "R6", "output without sample", 1, 0);
                    end else begin
                        if (d == 0) begin ev = q_val0.pop_front(); ec = q_cyc0.pop_front(); tg = q_tag0.pop_front(); end
                        else        begin ev = q_val1.pop_front(); ec = q_cyc1.pop_front(); tg = q_tag1.pop_front(); end
                        check(od[d] == ev, tg, "filter output", od[d], ev);
                        // R7 latency of one sample period
                        check(cyc - ec == steps_of(d), "R7", "latency", cyc - ec, steps_of(d));
                    end
                end
                prev_ov[d] = ov[d];
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int s;
        int dir [9] = '{-1, 127, -128, -128, 85, -86, 0, 0, 0};
        for (int d = 0; d < 2; d++) begin
            iv[d] = 0; id[d] = '0; last_acc[d] = -1; prev_ov[d] = 0;
            for (int t = 0; t < 4; t++) h[d][t] = 0;
        end
        repeat (4) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            // R1 reset state
            check(ir[d] == 1'b1, "R1", "ready in reset", ir[d], 1);
            check(ov[d] == 1'b0, "R1", "valid in reset", ov[d], 0);
        end
        rst = 0;
        @(negedge clk);
        check(ir[0] == 1'b1 && ov[0] == 1'b0, "R1", "after reset", ov[0], 0);
        s = 32'h1234567;
        for (int d = 0; d < 2; d++) begin
            // impulse exposes each coefficient in turn
            send(d, 1, 0, 0);
            for (int k = 0; k < 4; k++) send(d, 0, 0, 0);
            for (int k = 0; k < 9; k++) send(d, dir[k], 0, 0);
            // R8 data offered while not ready must be ignored
            for (int k = 0; k < 4; k++) send(d, 23 - 40*k, 1, 0);
            last_acc[d] = -1;
            for (int k = 0; k < 24; k++) begin
                s = s * 1103515245 + 12345;
                send(d, ((s >>> 16) & 255) - 128, 0, 1);
            end
            repeat (12) @(negedge clk);
        end
        check(q_val0.size() == 0, "R6", "pending outputs u0", q_val0.size(), 0);
        check(q_val1.size() == 0, "R9", "pending outputs u1", q_val1.size(), 0);
        report();
    end
endmodule